// File: doc/BRIEF.md
# Embedded Chip-Select Framing Decoder

This block recovers an active-low slave select from a serial link that carries only two signals: a shift clock and a data line. Framing is carried on the data line itself. In ordinary bit transfer the data line moves only while the shift clock is low. A data transition seen while the shift clock is high is therefore out of band. It is read as a frame marker, much as a two-wire bus recognises its start condition. The block runs on a fast system clock, brings both line signals in through two-flop synchronizers, and finds level changes by comparing each synchronized sample with the one before it.

Towards the slave, the block drives a select, a data line and a shift clock. Every data-bearing pulse from the line is rebuilt as one clean slave clock pulse with a fixed low-high-low shape, and the captured bit is held on the slave data line throughout. Pulses that carry a marker are never passed on, so the slave sees only real data bits. A parameter picks how a frame closes. In count mode the frame ends by itself after a set number of data pulses. In marker mode it ends when the data line makes the opposite transition while the shift clock is high.

Top module: `ecs_decoder`

## Requirements
- R1: While the synchronous active-high reset is applied, the select output is high, and the slave clock and slave data outputs are low.
- R2: A data-line change while the shift clock is low never opens a frame. While idle, the select stays high and no slave clock pulse appears.
- R3: While idle, a data-line change during a high shift clock drives the select low within 4 system clock cycles of the input change.
- R4: The shift-clock pulse that carries a start or end marker yields no slave clock pulse. The slave receives exactly the data bits sent between the markers.
- R5: Each data pulse of the line becomes exactly one slave clock pulse. The slave data output equals the data level seen at that pulse's rising edge, is set up at least PULSE_HALF system cycles before the slave clock rises, and holds steady while the slave clock is high.
- R6: In count mode (END_MODE = END_BY_COUNT), the select returns high by itself once the FRAME_BITS-th data pulse (default 8) has been delivered, with no further line activity.
- R7: In marker mode (END_MODE = END_BY_MARKER), the select returns high on the opposite-direction marker. A frame may carry any number of bits, including more than FRAME_BITS.
- R8: A rising start marker (data 0 to 1 with the clock high) is closed by a falling one, and a falling start marker is closed by a rising one. Both start polarities open a frame in both modes.
- R9: No slave clock pulse is driven while the select is high.
- R10: Inside a frame, any number of data-line changes while the shift clock is low affect nothing except the final level present at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the line shift clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk_i | input | 1 | Shift clock from the two-wire link (asynchronous) |
| line_dat_i | input | 1 | Data line from the two-wire link, also carrying the frame markers |
| slv_sclk_o | output | 1 | Rebuilt shift clock to the slave |
| slv_mosi_o | output | 1 | Data to the slave, held for the whole slave clock pulse |
| slv_csn_o | output | 1 | Recovered active-low select |

## Verification
If the frame-active flag goes wrong, the select port shows it at once. A stuck flag leaves the select low after a counted frame, and a falsely set flag lets slave clock pulses appear with the select high; either is visible within one line bit period. A wrong pulse-suppression flag or a wrong bit counter adds or drops a slave clock pulse. That shows up as a wrong bit count or a shifted word when the select next rises. A bad polarity latch shows up in marker mode as a frame that never closes, or that closes on the wrong edge.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    // How a frame is closed once it has been opened by a start marker.
    typedef enum logic {
        END_BY_COUNT  = 1'b0,
        END_BY_MARKER = 1'b1
    } end_mode_e;

    // Per-cycle view of the synchronized line, produced by the event stage.
    typedef struct packed {
        logic clk_lvl;   // synchronized shift clock level
        logic dat_lvl;   // synchronized data level
        logic clk_rise;  // shift clock went 0 -> 1
        logic clk_fall;  // shift clock went 1 -> 0
        logic marker;    // data moved while shift clock stayed high
    } line_evt_t;

    // Counter width able to hold the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ecs_sync.sv
module ecs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= din;
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/ecs_event.sv
module ecs_event (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_s,
    input  logic               dat_s,
    output ecs_pkg::line_evt_t evt
);
    logic clk_p;
    logic dat_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_p <= 1'b0;
            dat_p <= 1'b0;
        end else begin
            clk_p <= clk_s;
            dat_p <= dat_s;
        end
    end

    always_comb begin
        evt.clk_lvl  = clk_s;
        evt.dat_lvl  = dat_s;
        evt.clk_rise = clk_s & ~clk_p;
        evt.clk_fall = ~clk_s & clk_p;
        evt.marker   = clk_s & clk_p & (dat_s ^ dat_p);
    end
endmodule

// File: rtl/ecs_framer.sv
module ecs_framer #(
    parameter ecs_pkg::end_mode_e END_MODE   = ecs_pkg::END_BY_COUNT,
    parameter int                 FRAME_BITS = 8,
    parameter int                 CW         = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  ecs_pkg::line_evt_t evt,
    input  logic               pulse_done,
    output logic               active,
    output logic               launch,
    output logic               launch_bit,
    output logic [CW-1:0]      bit_cnt
);
    localparam logic [CW-1:0] LAST_CNT  = CW'(FRAME_BITS);
    localparam logic          BY_COUNT  = (END_MODE == ecs_pkg::END_BY_COUNT);

    logic pol;       // direction of the start marker (1 = rising)
    logic marked;    // current shift-clock pulse carried a marker
    logic bit_hold;  // data level captured at the last rising edge

    logic room;
    assign room       = !BY_COUNT || (bit_cnt < LAST_CNT);
    assign launch     = evt.clk_fall && active && !marked && room;
    assign launch_bit = bit_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            pol      <= 1'b0;
            marked   <= 1'b0;
            bit_hold <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            if (evt.clk_rise) begin
                marked   <= 1'b0;
                bit_hold <= evt.dat_lvl;
            end
            if (evt.marker) begin
                marked <= 1'b1;
                if (!active) begin
                    active  <= 1'b1;
                    pol     <= evt.dat_lvl;
                    bit_cnt <= '0;
                end else if (!BY_COUNT && (evt.dat_lvl != pol)) begin
                    active <= 1'b0;
                end
            end
            if (BY_COUNT) begin
                if (launch) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (pulse_done && active && (bit_cnt == LAST_CNT)) begin
                    active  <= 1'b0;
                    bit_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/ecs_pulse_gen.sv
module ecs_pulse_gen #(
    parameter int PULSE_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic bit_in,
    output logic sclk_o,
    output logic mosi_o,
    output logic done
);
    // Each pulse spans three phases of PULSE_HALF cycles: setup, high, hold.
    localparam int              TOTAL = 3 * PULSE_HALF;
    localparam int              GW    = $clog2(TOTAL + 1);
    localparam logic [GW-1:0]   G_TOT = GW'(TOTAL);
    localparam logic [GW-1:0]   G_LO  = GW'(PULSE_HALF);
    localparam logic [GW-1:0]   G_HI  = GW'(2 * PULSE_HALF);
    localparam logic [GW-1:0]   G_ONE = GW'(1);

    logic [GW-1:0] gen_cnt;
    logic [GW-1:0] gen_nxt;

    always_comb begin
        if (launch)            gen_nxt = G_TOT;
        else if (gen_cnt != '0) gen_nxt = gen_cnt - G_ONE;
        else                   gen_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_cnt <= '0;
            sclk_o  <= 1'b0;
            mosi_o  <= 1'b0;
        end else begin
            gen_cnt <= gen_nxt;
            sclk_o  <= (gen_nxt > G_LO) && (gen_nxt <= G_HI);
            if (launch) begin
                mosi_o <= bit_in;
            end
        end
    end

    assign done = (gen_cnt == G_ONE);
endmodule

// File: rtl/ecs_decoder.sv
module ecs_decoder #(
    parameter int                 FRAME_BITS  = 8,
    parameter ecs_pkg::end_mode_e END_MODE    = ecs_pkg::END_BY_COUNT,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 PULSE_HALF  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_clk_i,
    input  logic line_dat_i,
    output logic slv_sclk_o,
    output logic slv_mosi_o,
    output logic slv_csn_o
);
    localparam int CW = ecs_pkg::cnt_width(FRAME_BITS);

    logic [1:0]         line_s;
    ecs_pkg::line_evt_t evt;
    logic               active;
    logic               launch;
    logic               launch_bit;
    logic               pulse_done;
    logic [CW-1:0]      bit_cnt;

    ecs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({line_clk_i, line_dat_i}),
        .dout (line_s)
    );

    ecs_event u_event (
        .clk   (clk),
        .rst   (rst),
        .clk_s (line_s[1]),
        .dat_s (line_s[0]),
        .evt   (evt)
    );

    ecs_framer #(.END_MODE(END_MODE), .FRAME_BITS(FRAME_BITS), .CW(CW)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .pulse_done (pulse_done),
        .active     (active),
        .launch     (launch),
        .launch_bit (launch_bit),
        .bit_cnt    (bit_cnt)
    );

    ecs_pulse_gen #(.PULSE_HALF(PULSE_HALF)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .bit_in (launch_bit),
        .sclk_o (slv_sclk_o),
        .mosi_o (slv_mosi_o),
        .done   (pulse_done)
    );

    assign slv_csn_o = ~active;
endmodule

// File: rtl/ecs_decoder_chk.sv
module ecs_decoder_chk #(
    parameter int                 FRAME_BITS = 8,
    parameter ecs_pkg::end_mode_e END_MODE   = ecs_pkg::END_BY_COUNT,
    parameter int                 CW         = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          slv_sclk_o,
    input logic          slv_mosi_o,
    input logic          slv_csn_o,
    input logic          marker_evt,
    input logic          line_clk_lvl,
    input logic          pulse_done,
    input logic [CW-1:0] bit_cnt
);
    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_BITS);

    // R9: slave clock only inside a frame
    p_no_stray_clock_r9: assert property (@(posedge clk) disable iff (rst)
        slv_sclk_o |-> !slv_csn_o);

    // R5: slave data steady while slave clock is high
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (slv_sclk_o && $past(slv_sclk_o)) |-> (slv_mosi_o == $past(slv_mosi_o)));

    // R3: select falls only after a marker event
    p_select_from_marker_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(slv_csn_o) |-> $past(marker_evt));

    // R2: idle with shift clock low keeps the select high
    p_low_clock_no_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (slv_csn_o && !line_clk_lvl) |=> slv_csn_o);

    if (END_MODE == ecs_pkg::END_BY_COUNT) begin : g_count
        // R6: counter never passes the frame length
        p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
            bit_cnt <= LAST_CNT);
        // R6: counted frame closes only when the last pulse completes
        p_count_close_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(slv_csn_o) |-> $past(pulse_done));
    end else begin : g_marker
        // R7: marker frame closes only on a marker event
        p_marker_close_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(slv_csn_o) |-> $past(marker_evt));
    end
endmodule

bind ecs_decoder ecs_decoder_chk #(
    .FRAME_BITS (FRAME_BITS),
    .END_MODE   (END_MODE),
    .CW         (CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .slv_sclk_o   (slv_sclk_o),
    .slv_mosi_o   (slv_mosi_o),
    .slv_csn_o    (slv_csn_o),
    .marker_evt   (evt.marker),
    .line_clk_lvl (evt.clk_lvl),
    .pulse_done   (pulse_done),
    .bit_cnt      (bit_cnt)
);

// File: tb/ecs_decoder_tb.sv
`timescale 1ns/1ps
module ecs_decoder_tb;
    typedef struct {
        logic [31:0] bits;
        int          n;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lc [2];
    logic ld [2];
    logic sclk_o [2];
    logic mosi_o [2];
    logic csn_o  [2];

    int checks = 0;
    int errors = 0;
    int lat    = 0;
    exp_t exp_q0 [$];
    exp_t exp_q1 [$];

    always #2 clk = ~clk;   // 250 MHz

    ecs_decoder u_dut (
        .clk(clk), .rst(rst), .line_clk_i(lc[0]), .line_dat_i(ld[0]),
        .slv_sclk_o(sclk_o[0]), .slv_mosi_o(mosi_o[0]), .slv_csn_o(csn_o[0]));

    ecs_decoder #(.END_MODE(ecs_pkg::END_BY_MARKER)) u_dut_mk (
        .clk(clk), .rst(rst), .line_clk_i(lc[1]), .line_dat_i(ld[1]),
        .slv_sclk_o(sclk_o[1]), .slv_mosi_o(mosi_o[1]), .slv_csn_o(csn_o[1]));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One data bit: setup while low (optionally with extra toggles), pulse high.
    task automatic send_bit(input int w, input logic b, input bit wiggle);
        if (wiggle) begin
            for (int k = 0; k < 3; k++) begin
                ld[w] = ~b; cyc(2);
                ld[w] = b;  cyc(1);
            end
        end
        ld[w] = b;
        cyc(8);
        lc[w] = 1'b1;
        cyc(6);
        lc[w] = 1'b0;
        cyc(4);
    endtask

    // Marker: data moves while the shift clock is high. Records select latency.
    task automatic marker(input int w, input bit rising);
        ld[w] = ~rising;
        cyc(8);
        lc[w] = 1'b1;
        cyc(4);
        ld[w] = rising;
        lat = 99;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (!csn_o[w]) begin lat = k; break; end
        end
        cyc(6);
        lc[w] = 1'b0;
        cyc(8);
    endtask

    task automatic count_frame(input logic [7:0] v, input bit rising,
                               input bit wiggle, input string tag);
        exp_t e;
        e.bits = {24'h0, v}; e.n = 8; e.tag = tag;
        exp_q0.push_back(e);
        marker(0, rising);
        chk(lat <= 4, "R3", "count-mode select latency", lat, 4);
        for (int i = 7; i >= 0; i--) send_bit(0, v[i], wiggle);
        cyc(20);
        chk(csn_o[0] == 1'b1, "R6", "select high after last counted bit", csn_o[0], 1);
    endtask

    task automatic marker_frame(input logic [31:0] v, input int n,
                                input bit rising, input string tag);
        exp_t e;
        e.bits = v; e.n = n; e.tag = tag;
        exp_q1.push_back(e);
        marker(1, rising);
        chk(lat <= 4, "R3", "marker-mode select latency", lat, 4);
        for (int i = n - 1; i >= 0; i--) send_bit(1, v[i], 1'b0);
        cyc(4);
        chk(csn_o[1] == 1'b0, "R7", "select still low before end marker", csn_o[1], 0);
        marker(1, ~rising);
        cyc(4);
        chk(csn_o[1] == 1'b1, "R7 R8", "select high after opposite marker", csn_o[1], 1);
    endtask

    // Monitor: collects slave bits per frame and compares against the scoreboard.
    logic        prev_sclk [2];
    logic        prev_csn  [2];
    logic [31:0] acc [2];
    int          nb  [2];

    initial begin
        for (int w = 0; w < 2; w++) begin
            prev_sclk[w] = 1'b0; prev_csn[w] = 1'b1; acc[w] = '0; nb[w] = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int w = 0; w < 2; w++) begin
                if (sclk_o[w] && !prev_sclk[w]) begin
                    if (csn_o[w]) begin
                        chk(1'b0, "R9", "slave clock pulse with select high", 1, 0);
                    end else begin
                        acc[w] = {acc[w][30:0], mosi_o[w]};
                        nb[w]++;
                    end
                end
                if (!csn_o[w] && prev_csn[w]) begin
                    acc[w] = '0; nb[w] = 0;
                end
                if (csn_o[w] && !prev_csn[w]) begin
                    exp_t e;
                    bit   have;
                    have = (w == 0) ? (exp_q0.size() > 0) : (exp_q1.size() > 0);
                    if (!have) begin
                        chk(1'b0, "R2", "frame with no expected item", nb[w], 0);
                    end else begin
                        e = (w == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                        chk(nb[w] == e.n, e.tag, "slave bit count", nb[w], e.n);
                        chk(acc[w] == e.bits, e.tag, "slave word", acc[w], e.bits);
                    end
                end
                prev_sclk[w] = sclk_o[w];
                prev_csn[w]  = csn_o[w];
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        for (int w = 0; w < 2; w++) begin lc[w] = 1'b0; ld[w] = 1'b0; end
        cyc(5);
        @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            chk(csn_o[w] == 1'b1, "R1", "select in reset", csn_o[w], 1);
            chk(sclk_o[w] == 1'b0 && mosi_o[w] == 1'b0, "R1", "slave clock/data in reset",
                {sclk_o[w], mosi_o[w]}, 0);
        end
        cyc(1);
        rst = 1'b0;
        cyc(4);

        // R2: idle data toggles with shift clock low
        for (int k = 0; k < 10; k++) begin
            ld[0] = ~ld[0]; ld[1] = ~ld[1];
            cyc(3);
            if (k % 3 == 0) begin
                chk(csn_o[0] && csn_o[1], "R2", "select high during low-clock toggles",
                    {csn_o[0], csn_o[1]}, 3);
            end
        end
        cyc(10);

        // Count mode: R4 R5 R6 and both start polarities (R8)
        count_frame(8'hA5, 1'b1, 1'b0, "R4 R5 R6");
        count_frame(8'h3C, 1'b0, 1'b0, "R8 R6");
        // R10: extra low-clock toggles inside a frame
        count_frame(8'h96, 1'b1, 1'b1, "R10");

        // Marker mode: short, long, both polarities
        marker_frame(32'h16, 5, 1'b1, "R7 R4");
        marker_frame(32'hC3A, 12, 1'b0, "R7 R8");
        marker_frame(32'h1, 1, 1'b1, "R7 R5");

        cyc(30);
        chk(exp_q0.size() == 0, "R6", "count frames left unchecked", exp_q0.size(), 0);
        chk(exp_q1.size() == 0, "R7", "marker frames left unchecked", exp_q1.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule